// File: doc/BRIEF.md
# Windowed Commit FIFO Channel

This block is a single-writer, single-reader token buffer placed between two dataflow actors. Unlike an ordinary FIFO, neither side moves the pointers simply by accessing data. The reading actor inspects any token inside its available window by giving an offset from the oldest token. The writing actor fills any free place by giving an offset from the first free slot. Data changes hands only when an actor issues a commit with a count. A consume commit retires that many tokens from the head. A produce commit publishes that many places from the tail.

Two counts are driven continuously: the tokens ready to read and the places free to write. An actor's firing controller compares them with the token and place numbers it needs before it fires. After reset the buffer can already hold a number of initial tokens, taken from a packed parameter vector. Token k of that sequence sits in bits `k*DATA_W +: DATA_W` and is seen at read offset k.

Storage and the pointer/count logic are separate modules. The controller classifies each commit as idle, accepted or rejected, and that verdict alone decides how the head pointer and the count move in that cycle. No larger state machine is needed. The "state" is the pair (head pointer, available count), and its only transitions are the accepted commits.

Top module: `fifo_win_chan`

## Requirements
- R1: While `rst_n` is low, `avail` becomes N_INIT and `free` becomes DEPTH-N_INIT. Read offset k (k < N_INIT) then returns bits `k*DATA_W +: DATA_W` of INIT_VEC.
- R2: With `peek_en` high and `peek_off` < `avail`, `peek_data` shows in the same cycle the token at that offset from the oldest one (offset 0 is the oldest). Peeking never changes `avail`.
- R3: `peek_err` is high in the same cycle exactly when `peek_en` is high and `peek_off` >= `avail`.
- R4: With `poke_en` high and `poke_off` < `free`, `poke_data` is stored at the edge into the place at that offset past the newest token. The stored value is not counted in `avail` until a produce commit covers it.
- R5: `poke_err` is high in the same cycle exactly when `poke_en` is high and `poke_off` >= `free`. Such a poke stores nothing, and every available token keeps its value.
- R6: An accepted consume commit (`cons_en` high, `cons_cnt` <= `avail`) removes `cons_cnt` tokens from the head at the edge. After the edge, the token that was at offset `cons_cnt` is at offset 0.
- R7: An accepted produce commit (`prod_en` high, `prod_cnt` <= `free`) makes the first `prod_cnt` free places visible at the edge, in offset order, behind the existing tokens.
- R8: A consume commit with `cons_cnt` > `avail` raises `cons_err` in the same cycle, and neither the head nor the counts move.
- R9: A produce commit with `prod_cnt` > `free` raises `prod_err` in the same cycle, and neither the tail nor the counts move.
- R10: Both commits are judged against the counts from before the edge. When both are accepted in one cycle, the next `avail` is `avail - cons_cnt + prod_cnt`.
- R11: `avail` never exceeds DEPTH, and `free` always equals DEPTH - `avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; loads the initial tokens |
| peek_en | input | 1 | Read access request |
| peek_off | input | $clog2(DEPTH) | Read offset from the oldest token |
| peek_data | output | DATA_W | Token at the read offset |
| peek_err | output | 1 | Read offset outside the available window |
| poke_en | input | 1 | Write access request |
| poke_off | input | $clog2(DEPTH) | Write offset from the first free place |
| poke_data | input | DATA_W | Value to store |
| poke_err | output | 1 | Write offset outside the free window |
| cons_en | input | 1 | Consume commit request |
| cons_cnt | input | $clog2(DEPTH+1) | Number of tokens to retire |
| cons_err | output | 1 | Consume count exceeds available tokens |
| prod_en | input | 1 | Produce commit request |
| prod_cnt | input | $clog2(DEPTH+1) | Number of places to publish |
| prod_err | output | 1 | Produce count exceeds free places |
| avail | output | $clog2(DEPTH+1) | Tokens available to the reader |
| free | output | $clog2(DEPTH+1) | Places free to the writer |

## Verification
The assertions assume that the enables and counts are never unknown after reset, and that DEPTH is a power of two so that the pointer sums wrap naturally. They do not assume that offsets or counts are legal. Out-of-window offsets and counts up to DEPTH+1 are treated as ordinary stimulus whose only correct outcome is an error flag with no state change. The bench changes every input just after a falling edge and reads the combinational flags a moment later. A rejected poke is aimed at an offset that wraps onto live tokens, so a missing guard would show up as a corrupted peek value.

// File: rtl/fifo_win_pkg.sv
package fifo_win_pkg;

    // Outcome of one commit request in the current cycle
    typedef enum logic [1:0] {
        CR_IDLE,
        CR_ACCEPT,
        CR_REJECT
    } commit_res_e;

    function automatic commit_res_e judge_commit(input logic en, input logic fits);
        if (!en)
            return CR_IDLE;
        else if (fits)
            return CR_ACCEPT;
        else
            return CR_REJECT;
    endfunction

endpackage

// File: rtl/fifo_win_store.sv
module fifo_win_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int N_INIT = 3,
    parameter logic [DEPTH*DATA_W-1:0] INIT_VEC = '0,
    localparam int OFF_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Reset preloads the initial token sequence starting at slot 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < N_INIT) ? INIT_VEC[i*DATA_W +: DATA_W] : '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fifo_win_ctrl.sv
module fifo_win_ctrl
    import fifo_win_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int N_INIT = 3,
    localparam int OFF_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             peek_en,
    input  logic [OFF_W-1:0] peek_off,
    input  logic             poke_en,
    input  logic [OFF_W-1:0] poke_off,
    input  logic             cons_en,
    input  logic [CNT_W-1:0] cons_cnt,
    input  logic             prod_en,
    input  logic [CNT_W-1:0] prod_cnt,
    output logic             peek_err,
    output logic             poke_err,
    output logic             cons_err,
    output logic             prod_err,
    output logic [OFF_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_addr,
    output logic [CNT_W-1:0] avail,
    output logic [CNT_W-1:0] free
);

    logic [OFF_W-1:0] head_q;
    logic [CNT_W-1:0] avail_q;
    logic [OFF_W-1:0] tail;
    logic [CNT_W-1:0] free_w;
    logic [CNT_W-1:0] take;
    logic [CNT_W-1:0] give;
    commit_res_e      cons_res;
    commit_res_e      prod_res;

    assign free_w = CNT_W'(DEPTH) - avail_q;
    // A full buffer has tail == head; low bits of the count wrap correctly
    assign tail   = head_q + avail_q[OFF_W-1:0];

    // Both commits are judged against the counts before this edge
    assign cons_res = judge_commit(cons_en, cons_cnt <= avail_q);
    assign prod_res = judge_commit(prod_en, prod_cnt <= free_w);

    always_comb begin
        unique case (cons_res)
            CR_ACCEPT:          take = cons_cnt;
            CR_IDLE, CR_REJECT: take = '0;
            default:            take = '0;
        endcase
        unique case (prod_res)
            CR_ACCEPT:          give = prod_cnt;
            CR_IDLE, CR_REJECT: give = '0;
            default:            give = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            avail_q <= CNT_W'(N_INIT);
        end else begin
            head_q  <= head_q + take[OFF_W-1:0];
            avail_q <= avail_q - take + give;
        end
    end

    assign cons_err = (cons_res == CR_REJECT);
    assign prod_err = (prod_res == CR_REJECT);
    assign peek_err = peek_en && (CNT_W'(peek_off) >= avail_q);
    assign poke_err = poke_en && (CNT_W'(poke_off) >= free_w);

    assign rd_addr = head_q + peek_off;
    assign wr_addr = tail + poke_off;
    assign wr_en   = poke_en && !poke_err;

    assign avail = avail_q;
    assign free  = free_w;

endmodule

// File: rtl/fifo_win_chan.sv
module fifo_win_chan #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int N_INIT = 3,
    parameter logic [DEPTH*DATA_W-1:0] INIT_VEC = 64'h0000_0000_00A2_A1A0,
    localparam int OFF_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peek_en,
    input  logic [OFF_W-1:0]  peek_off,
    output logic [DATA_W-1:0] peek_data,
    output logic              peek_err,
    input  logic              poke_en,
    input  logic [OFF_W-1:0]  poke_off,
    input  logic [DATA_W-1:0] poke_data,
    output logic              poke_err,
    input  logic              cons_en,
    input  logic [CNT_W-1:0]  cons_cnt,
    output logic              cons_err,
    input  logic              prod_en,
    input  logic [CNT_W-1:0]  prod_cnt,
    output logic              prod_err,
    output logic [CNT_W-1:0]  avail,
    output logic [CNT_W-1:0]  free
);

    logic [OFF_W-1:0] rd_addr;
    logic [OFF_W-1:0] wr_addr;
    logic             wr_en;

    fifo_win_ctrl #(
        .DEPTH  (DEPTH),
        .N_INIT (N_INIT)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .peek_en  (peek_en),
        .peek_off (peek_off),
        .poke_en  (poke_en),
        .poke_off (poke_off),
        .cons_en  (cons_en),
        .cons_cnt (cons_cnt),
        .prod_en  (prod_en),
        .prod_cnt (prod_cnt),
        .peek_err (peek_err),
        .poke_err (poke_err),
        .cons_err (cons_err),
        .prod_err (prod_err),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .avail    (avail),
        .free     (free)
    );

    fifo_win_store #(
        .DEPTH    (DEPTH),
        .DATA_W   (DATA_W),
        .N_INIT   (N_INIT),
        .INIT_VEC (INIT_VEC)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (poke_data),
        .rd_addr (rd_addr),
        .rd_data (peek_data)
    );

endmodule

// File: rtl/fifo_win_chan_chk.sv
module fifo_win_chan_chk #(
    parameter int DEPTH = 8,
    localparam int OFF_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             peek_en,
    input logic [OFF_W-1:0] peek_off,
    input logic             peek_err,
    input logic             poke_en,
    input logic [OFF_W-1:0] poke_off,
    input logic             poke_err,
    input logic             cons_en,
    input logic [CNT_W-1:0] cons_cnt,
    input logic             cons_err,
    input logic             prod_en,
    input logic [CNT_W-1:0] prod_cnt,
    input logic             prod_err,
    input logic [CNT_W-1:0] avail,
    input logic [CNT_W-1:0] free
);

    // R11
    avail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= CNT_W'(DEPTH));

    // R3
    peek_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_en && CNT_W'(peek_off) >= avail) |-> peek_err);

    // R5
    poke_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poke_en && CNT_W'(poke_off) >= free) |-> poke_err);

    // R8
    cons_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_en && cons_cnt > avail && !prod_en) |=> $stable(avail));

    // R9
    prod_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_en && prod_cnt > free && !cons_en) |=> $stable(avail));

    // R10
    dual_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_en && !cons_err && prod_en && !prod_err)
        |=> avail == $past(avail) - $past(cons_cnt) + $past(prod_cnt));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cons_en && !prod_en) |=> $stable(avail));

endmodule

bind fifo_win_chan fifo_win_chan_chk #(.DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .peek_en  (peek_en),
    .peek_off (peek_off),
    .peek_err (peek_err),
    .poke_en  (poke_en),
    .poke_off (poke_off),
    .poke_err (poke_err),
    .cons_en  (cons_en),
    .cons_cnt (cons_cnt),
    .cons_err (cons_err),
    .prod_en  (prod_en),
    .prod_cnt (prod_cnt),
    .prod_err (prod_err),
    .avail    (avail),
    .free     (free)
);

// File: tb/fifo_win_chan_tb.sv
module fifo_win_chan_tb_top;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 8;
    localparam int N_INIT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       peek_en = 1'b0;
    logic [2:0] peek_off = '0;
    logic [7:0] peek_data;
    logic       peek_err;
    logic       poke_en = 1'b0;
    logic [2:0] poke_off = '0;
    logic [7:0] poke_data = '0;
    logic       poke_err;
    logic       cons_en = 1'b0;
    logic [3:0] cons_cnt = '0;
    logic       cons_err;
    logic       prod_en = 1'b0;
    logic [3:0] prod_cnt = '0;
    logic       prod_err;
    logic [3:0] avail;
    logic [3:0] free;

    int total = 0;
    int bad   = 0;

    // Reference state derived from the requirements
    int m_mem [DEPTH];
    int m_head;
    int m_avail;

    always #5 clk = ~clk;

    fifo_win_chan #(
        .DEPTH    (DEPTH),
        .DATA_W   (DATA_W),
        .N_INIT   (N_INIT),
        .INIT_VEC (64'h0000_0000_00A2_A1A0)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .peek_en   (peek_en),
        .peek_off  (peek_off),
        .peek_data (peek_data),
        .peek_err  (peek_err),
        .poke_en   (poke_en),
        .poke_off  (poke_off),
        .poke_data (poke_data),
        .poke_err  (poke_err),
        .cons_en   (cons_en),
        .cons_cnt  (cons_cnt),
        .cons_err  (cons_err),
        .prod_en   (prod_en),
        .prod_cnt  (prod_cnt),
        .prod_err  (prod_err),
        .avail     (avail),
        .free      (free)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check combinational
    // outputs, then advance the reference state at the rising edge.
    task automatic step(input logic pe, input int po, input logic ke, input int ko,
                        input int kd, input logic ce, input int cc,
                        input logic pre, input int pc);
        logic e_peek, e_poke, e_cons, e_prod;
        int   m_free;
        @(negedge clk);
        peek_en   = pe;
        peek_off  = 3'(po);
        poke_en   = ke;
        poke_off  = 3'(ko);
        poke_data = 8'(kd);
        cons_en   = ce;
        cons_cnt  = 4'(cc);
        prod_en   = pre;
        prod_cnt  = 4'(pc);
        #1;
        m_free = DEPTH - m_avail;
        chk("R10 avail", int'(avail), m_avail);
        chk("R11 free", int'(free), m_free);
        e_peek = pe && (po >= m_avail);
        chk("R3 peek_err", int'(peek_err), int'(e_peek));
        if (pe && !e_peek)
            chk("R2 peek_data", int'(peek_data), m_mem[(m_head + po) % DEPTH]);
        e_poke = ke && (ko >= m_free);
        chk("R5 poke_err", int'(poke_err), int'(e_poke));
        e_cons = ce && (cc > m_avail);
        if (ce) chk("R8 cons_err", int'(cons_err), int'(e_cons));
        e_prod = pre && (pc > m_free);
        if (pre) chk("R9 prod_err", int'(prod_err), int'(e_prod));
        if (ke && !e_poke)
            m_mem[(m_head + m_avail + ko) % DEPTH] = kd;
        @(posedge clk);
        if (ce && !e_cons) begin
            m_head  = (m_head + cc) % DEPTH;
            m_avail = m_avail - cc;
        end
        if (pre && !e_prod)
            m_avail = m_avail + pc;
    endtask

    task automatic idle_peek(input int po);
        step(1'b1, po, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        m_mem[0] = 'hA0;
        m_mem[1] = 'hA1;
        m_mem[2] = 'hA2;
        m_head  = 0;
        m_avail = N_INIT;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: counts and preloaded tokens after reset
        #1;
        chk("R1 avail", int'(avail), N_INIT);
        chk("R1 free", int'(free), DEPTH - N_INIT);
        for (int o = 0; o < DEPTH; o++) idle_peek(o);

        // R5: out-of-window poke wraps onto live token slot 0; must not store
        step(1'b0, 0, 1'b1, 5, 'hFF, 1'b0, 0, 1'b0, 0);
        for (int o = 0; o < N_INIT; o++) idle_peek(o);

        // R4: legal poke is stored but not yet counted
        step(1'b0, 0, 1'b1, 0, 'h11, 1'b0, 0, 1'b0, 0);
        #1;
        chk("R4 avail unchanged", int'(avail), N_INIT);

        // R8 / R9: oversized commits rejected
        step(1'b0, 0, 1'b0, 0, 0, 1'b1, 4, 1'b0, 0);
        step(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 1'b1, 6);
        #1;
        chk("R8 R9 avail held", int'(avail), N_INIT);

        // R10: consume 2 and produce 1 together
        step(1'b0, 0, 1'b0, 0, 0, 1'b1, 2, 1'b1, 1);
        #1;
        chk("R10 dual commit", int'(avail), 2);
        // R6 / R7: head moved by 2, poked token now visible behind it
        step(1'b1, 0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
        chk("R6 head token", int'(peek_data), 'hA2);
        step(1'b1, 1, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0);
        chk("R7 published token", int'(peek_data), 'h11);

        // Mixed sweep of offsets, counts and enables
        for (int k = 0; k < 400; k++) begin
            step(1'b1, (k * 7 + 1) % DEPTH,
                 (k % 2) == 0, (k * 3) % DEPTH, k & 'hFF,
                 (k % 3) != 1, (k * 5) % 10,
                 (k % 4) != 3, (k * 3 + 1) % 9);
        end

        // Boundary: drain to empty
        step(1'b0, 0, 1'b0, 0, 0, 1'b1, m_avail, 1'b0, 0);
        #1;
        chk("R6 drained", int'(avail), 0);
        idle_peek(0);
        // Fill every place, then publish all at once
        for (int o = 0; o < DEPTH; o++)
            step(1'b0, 0, 1'b1, o, 'hC0 + o, 1'b0, 0, 1'b0, 0);
        step(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 1'b1, DEPTH);
        #1;
        chk("R7 full avail", int'(avail), DEPTH);
        chk("R11 full free", int'(free), 0);
        step(1'b0, 0, 1'b1, 0, 'hEE, 1'b0, 0, 1'b0, 0);
        for (int o = 0; o < DEPTH; o++) begin
            idle_peek(o);
            chk("R7 full order", int'(peek_data), 'hC0 + o);
        end
        step(1'b0, 0, 1'b0, 0, 0, 1'b1, DEPTH + 1, 1'b1, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule